// File: doc/BRIEF.md
# Floating-Point Operand Unboxer

This block takes one 64-bit floating-point register value and returns the operand it holds in a requested format: half precision, bfloat16, single precision or double precision. A value narrower than 64 bits counts as valid only when every bit above it is one. If a narrow value fails that test, the block returns the canonical quiet NaN of the requested format instead. Half precision and bfloat16 use the same test, but each has its own NaN pattern.

A second mode takes the operand from the integer register file instead. In that mode the low bits of the integer register are used directly, with no box test. A double-precision operand is the full register when XLEN is 64. When XLEN is 32 it is built from a pair of registers. The block is purely combinational. It sits between the register read ports and the execution units, and an operand is ready in the same cycle its inputs are.

Top module: `fp_operand_unbox`

## Requirements
- R1: With the FP path selected, a half (fmtSel=0) or bfloat16 (fmtSel=1) operand whose register bits 63:16 are all ones is returned as bits 15:0 zero-extended to 64 bits, with boxedOk=1.
- R2: With the FP path selected, a 16-bit operand is treated as not boxed when any bit in 63:16 is zero, and boxedOk is then 0.
- R3: A half operand that is not boxed is replaced by 64'h0000_0000_0000_7E00.
- R4: A bfloat16 operand that is not boxed is replaced by 64'h0000_0000_0000_7FC0, never by the half NaN. For example, the register value 64'h0000_0000_0000_7D2D yields 64'h7FC0.
- R5: With the FP path selected, a single operand (fmtSel=2) whose bits 63:32 are all ones is returned as bits 31:0 zero-extended, with boxedOk=1.
- R6: A single operand whose bits 63:32 are not all ones is replaced by 64'h0000_0000_7FC0_0000, with boxedOk=0.
- R7: A double operand (fmtSel=3) on the FP path is the register value unchanged, with boxedOk=1.
- R8: With intMode=1, a half or bfloat16 operand is intRegLo[15:0] zero-extended, with no box test and boxedOk=1.
- R9: With intMode=1, a single operand is intRegLo[31:0] zero-extended, with boxedOk=1.
- R10: With intMode=1 and xlen64=1, a double operand is intRegLo unchanged.
- R11: With intMode=1 and xlen64=0, a double operand is {intRegHi[31:0], intRegLo[31:0]}.
- R12: The outputs depend only on the present inputs, with no clock and no stored state. Exactly one operand width is selected at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fpReg | input | 64 | Floating-point register value |
| intRegLo | input | 64 | Integer register value; the low word of a pair when XLEN is 32 |
| intRegHi | input | 32 | High word of the integer register pair when XLEN is 32 |
| fmtSel | input | 2 | Requested format: 0 half, 1 bfloat16, 2 single, 3 double |
| xlen64 | input | 1 | 1 when XLEN is 64, 0 when XLEN is 32 |
| intMode | input | 1 | 1 takes the operand from the integer register(s) |
| operand | output | 64 | Extracted operand, zero-extended |
| boxedOk | output | 1 | 1 when the operand was properly boxed or needs no box test |

## Verification
Every format is tried on both paths with three kinds of upper field: all ones, all ones except a single zero bit, and all zeros. The single-zero pattern shows whether the test covers the whole upper field or only part of it. The all-zero pattern, including the 7D2D value, shows whether the bfloat16 NaN is kept apart from the half NaN. On the integer path the same upper-field garbage is placed in the integer register, which shows that no box test is applied there. The XLEN=32 double case shows that the register pair is joined in the right order.

// File: rtl/fp_unbox_pkg.sv
package fp_unbox_pkg;
  localparam int FLEN    = 64;
  localparam int HALF_W  = 16;
  localparam int SINGLE_W = 32;
  localparam int PAIR_W  = FLEN / 2;

  localparam logic [FLEN-1:0] HALF_QNAN   = 64'h0000_0000_0000_7E00;
  localparam logic [FLEN-1:0] BF16_QNAN   = 64'h0000_0000_0000_7FC0;
  localparam logic [FLEN-1:0] SINGLE_QNAN = 64'h0000_0000_7FC0_0000;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take16;
    logic take32;
    logic take64;
    logic fromInt;
    logic joinPair;
    logic bfNan;
  } unboxStrobes_t;
endpackage

// File: rtl/unbox_ctrl.sv
module unbox_ctrl
  import fp_unbox_pkg::*;
(
  input  logic [1:0]    fmtSel,
  input  logic          xlen64,
  input  logic          intMode,
  output unboxStrobes_t strobes
);
  fmt_e fmt;

  always_comb begin
    fmt = fmt_e'(fmtSel);
    strobes = '0;
    strobes.fromInt = intMode;
    unique case (fmt)
      FMT_HALF:   strobes.take16 = 1'b1;
      FMT_BF16: begin
        strobes.take16 = 1'b1;
        strobes.bfNan  = 1'b1;
      end
      FMT_SINGLE: strobes.take32 = 1'b1;
      FMT_DOUBLE: begin
        strobes.take64   = 1'b1;
        strobes.joinPair = intMode & ~xlen64;
      end
      default: strobes.take64 = 1'b1;
    endcase
  end

  always_comb begin
    AST_ONE_WIDTH: assert ($onehot({strobes.take16, strobes.take32, strobes.take64})); // R12
    if (strobes.bfNan) begin
      AST_BF_IS_16: assert (strobes.take16); // R4
    end
  end
endmodule

// File: rtl/unbox_datapath.sv
module unbox_datapath
  import fp_unbox_pkg::*;
(
  input  logic [FLEN-1:0]   fpReg,
  input  logic [FLEN-1:0]   intRegLo,
  input  logic [PAIR_W-1:0] intRegHi,
  input  unboxStrobes_t     strobes,
  output logic [FLEN-1:0]   operand,
  output logic              boxedOk
);
  localparam int UP16_W = FLEN - HALF_W;
  localparam int UP32_W = FLEN - SINGLE_W;

  logic            box16Ok;
  logic            box32Ok;
  logic [FLEN-1:0] fpOperand;
  logic [FLEN-1:0] intOperand;
  logic            fpOk;

  assign box16Ok = &fpReg[FLEN-1:HALF_W];
  assign box32Ok = &fpReg[FLEN-1:SINGLE_W];

  always_comb begin
    fpOperand = fpReg;
    fpOk      = 1'b1;
    if (strobes.take16) begin
      fpOk = box16Ok;
      if (box16Ok)            fpOperand = {{UP16_W{1'b0}}, fpReg[HALF_W-1:0]};
      else if (strobes.bfNan) fpOperand = BF16_QNAN;
      else                    fpOperand = HALF_QNAN;
    end else if (strobes.take32) begin
      fpOk = box32Ok;
      fpOperand = box32Ok ? {{UP32_W{1'b0}}, fpReg[SINGLE_W-1:0]} : SINGLE_QNAN;
    end
  end

  always_comb begin
    if (strobes.take16)        intOperand = {{UP16_W{1'b0}}, intRegLo[HALF_W-1:0]};
    else if (strobes.take32)   intOperand = {{UP32_W{1'b0}}, intRegLo[SINGLE_W-1:0]};
    else if (strobes.joinPair) intOperand = {intRegHi, intRegLo[PAIR_W-1:0]};
    else                       intOperand = intRegLo;
  end

  assign operand = strobes.fromInt ? intOperand : fpOperand;
  assign boxedOk = strobes.fromInt ? 1'b1 : fpOk;

  always_comb begin
    if (strobes.fromInt) begin
      AST_INT_NO_CHECK: assert (boxedOk); // R8
    end
    if (strobes.take16) begin
      AST_ZERO_EXT16: assert (operand[FLEN-1:HALF_W] == '0); // R1
    end
    if (strobes.take32) begin
      AST_ZERO_EXT32: assert (operand[FLEN-1:SINGLE_W] == '0); // R5
    end
    if (!strobes.fromInt && strobes.take64) begin
      AST_DOUBLE_PASS: assert (boxedOk && operand == fpReg); // R7
    end
    if (!strobes.fromInt && strobes.bfNan && !box16Ok) begin
      AST_BF_NAN: assert (operand != HALF_QNAN); // R4
    end
  end
endmodule

// File: rtl/fp_operand_unbox.sv
module fp_operand_unbox
  import fp_unbox_pkg::*;
(
  input  logic [63:0] fpReg,
  input  logic [63:0] intRegLo,
  input  logic [31:0] intRegHi,
  input  logic [1:0]  fmtSel,
  input  logic        xlen64,
  input  logic        intMode,
  output logic [63:0] operand,
  output logic        boxedOk
);
  unboxStrobes_t strobes;

  unbox_ctrl u_ctrl (
    .fmtSel  (fmtSel),
    .xlen64  (xlen64),
    .intMode (intMode),
    .strobes (strobes)
  );

  unbox_datapath u_dp (
    .fpReg    (fpReg),
    .intRegLo (intRegLo),
    .intRegHi (intRegHi),
    .strobes  (strobes),
    .operand  (operand),
    .boxedOk  (boxedOk)
  );
endmodule

// File: tb/sim_fp_operand_unbox.sv
module sim_fp_operand_unbox;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] expOp;
    logic        expOk;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] fpReg = '0;
  logic [63:0] intRegLo = '0;
  logic [31:0] intRegHi = '0;
  logic [1:0]  fmtSel = '0;
  logic        xlen64 = 1'b1;
  logic        intMode = 1'b0;
  logic [63:0] operand;
  logic        boxedOk;

  item_t sbQ[$];
  int    nRun = 0;
  int    nFail = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_operand_unbox u0 (
    .fpReg(fpReg), .intRegLo(intRegLo), .intRegHi(intRegHi),
    .fmtSel(fmtSel), .xlen64(xlen64), .intMode(intMode),
    .operand(operand), .boxedOk(boxedOk)
  );

  // monitor: compare half a cycle after each drive
  always @(posedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      nRun++;
      if (operand !== it.expOp || boxedOk !== it.expOk) begin
        nFail++;
        $display("FAIL %s: operand=%h ok=%b expected operand=%h ok=%b",
                 it.tag, operand, boxedOk, it.expOp, it.expOk);
      end
    end
  end

  task automatic drive(input logic [63:0] fp, input logic [63:0] lo, input logic [31:0] hi,
                       input logic [1:0] fmt, input logic im, input logic x64,
                       input logic [63:0] expOp, input logic expOk, input string tag);
    item_t it;
    @(negedge clk);
    fpReg = fp; intRegLo = lo; intRegHi = hi;
    fmtSel = fmt; intMode = im; xlen64 = x64;
    it.expOp = expOp; it.expOk = expOk; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // upper field: 0 all ones, 1 one zero bit at position z, 2 all zeros
  function automatic logic [63:0] mkReg(input int pat, input int lowW, input int z,
                                        input logic [63:0] payload);
    logic [63:0] r;
    logic [63:0] lowMask;
    lowMask = (64'd1 << lowW) - 64'd1;
    r = payload & lowMask;
    if (pat == 0)      r = r | ~lowMask;
    else if (pat == 1) r = (r | ~lowMask) & ~(64'd1 << (lowW + z));
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // idle inputs: half from zeroed register -> half NaN (R3)
    drive(64'h0, 64'h0, 32'h0, 2'd0, 1'b0, 1'b1, 64'h7E00, 1'b0, "R3 idle");
    // 7D2D read as bfloat16 (R4)
    drive(64'h0000_0000_0000_7D2D, 64'h0, 32'h0, 2'd1, 1'b0, 1'b1, 64'h7FC0, 1'b0, "R4 7D2D");
    drive(64'h0000_0000_0000_7D2D, 64'h0, 32'h0, 2'd0, 1'b0, 1'b1, 64'h7E00, 1'b0, "R3 7D2D");

    for (int fmt = 0; fmt < 4; fmt++) begin
      for (int im = 0; im < 2; im++) begin
        for (int pat = 0; pat < 3; pat++) begin
          for (int x = 0; x < 2; x++) begin
            logic [63:0] payload;
            logic [63:0] fp;
            logic [63:0] lo;
            logic [31:0] hi;
            logic [63:0] eOp;
            logic        eOk;
            int          lowW;
            int          z;
            string       tag;
            payload = 64'h1357_9BDF_2468_ACE0 ^ (64'(fmt * 97 + pat * 13 + im * 5 + x) << 3);
            lowW = (fmt < 2) ? 16 : (fmt == 2 ? 32 : 64);
            z = (fmt * 11 + im * 7 + pat * 3 + x * 17) % ((lowW == 16) ? 48 : 32);
            hi = 32'hCAFE_0000 + 32'(fmt * 16 + pat);
            if (lowW == 64) begin
              fp = (pat == 0) ? payload : (pat == 1 ? ~payload : 64'h0);
              lo = fp ^ 64'h0F0F_0000_F0F0_0000;
            end else begin
              fp = mkReg(pat, lowW, z, payload);
              lo = mkReg(pat, lowW, (z + 5) % (64 - lowW), ~payload);
            end
            if (im == 1) begin
              eOk = 1'b1;
              if (fmt < 2) begin
                eOp = {48'h0, lo[15:0]}; tag = "R8 int 16-bit";
              end else if (fmt == 2) begin
                eOp = {32'h0, lo[31:0]}; tag = "R9 int single";
              end else if (x == 1) begin
                eOp = lo; tag = "R10 int double xlen64";
              end else begin
                eOp = {hi, lo[31:0]}; tag = "R11 int double pair";
              end
            end else if (fmt == 3) begin
              eOp = fp; eOk = 1'b1; tag = "R7 double";
            end else if (pat == 0) begin
              eOk = 1'b1;
              if (fmt < 2) begin eOp = {48'h0, fp[15:0]}; tag = "R1 boxed 16-bit"; end
              else begin eOp = {32'h0, fp[31:0]}; tag = "R5 boxed single"; end
            end else begin
              eOk = 1'b0;
              if (fmt == 0)      begin eOp = 64'h7E00; tag = "R2 R3 half unboxed"; end
              else if (fmt == 1) begin eOp = 64'h7FC0; tag = "R2 R4 bf16 unboxed"; end
              else               begin eOp = 64'h7FC0_0000; tag = "R6 single unboxed"; end
            end
            drive(fp, lo, hi, 2'(fmt), im[0], x[0], eOp, eOk, tag);
          end
        end
      end
    end

    // R12: back-to-back changes, result follows each input with no latency
    drive(64'hFFFF_FFFF_FFFF_3C00, 64'h0, 32'h0, 2'd0, 1'b0, 1'b1, 64'h3C00, 1'b1, "R12 step a");
    drive(64'hFFFF_FFFF_FFFF_3C00, 64'h0, 32'h0, 2'd2, 1'b0, 1'b1, 64'hFFFF_3C00, 1'b1, "R12 step b");
    drive(64'hFFFF_FFFF_FFFF_3C00, 64'h0, 32'h0, 2'd1, 1'b0, 1'b1, 64'h3C00, 1'b1, "R12 step c");

    @(negedge clk);
    while (sbQ.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule